// File: doc/BRIEF.md
# Endpoint Test Command Engine

This block is the test function of a bus endpoint. Host software reaches it through a small word-indexed register file. That file holds a scratch pattern, a command word, a status word, two host buffer addresses, a transfer length, a checksum, and an interrupt kind and vector. A single write to the command word starts one job. The job is one of four kinds: raising an interrupt request on its own, fetching a host buffer and folding it into a checksum, filling a host buffer with a generated pattern, or moving a buffer from one host location to another.

Memory traffic uses a simple word-wide master port with a request/acknowledge handshake. Interrupts leave the block as an abstract one-cycle request that carries a kind and a vector number. Every buffer job checks its addresses against a configured host window before it touches memory. It then records success or failure, together with the offending address, in the status word. Last, it announces completion with an interrupt of the programmed kind, provided that the programmed kind and vector form a legal pair.

Top module: `ep_test_engine`

## Requirements
- R1: Register index 0 is a scratch pattern register that reads back exactly the last 32-bit value written to it. All registers reset to zero.
- R2: Register indices are as follows: 1 command, 2 status, 3 source address, 4 destination address, 5 length in 32-bit words, 6 checksum (read-only), 7 interrupt kind and 8 interrupt vector. Writes to index 6 are ignored. Unmapped indices read zero.
- R3: In the command word, bits 0, 1 and 2 request a legacy, MSI and MSI-X interrupt respectively. Bit 3 requests a buffer read, bit 4 a buffer write and bit 5 a buffer copy. When several bits are set, only the lowest-numbered one is performed. The command word reads zero once the job has started.
- R4: Interrupt kind codes are 0 legacy, 1 MSI and 2 MSI-X. A request is legal only when the vector is 0 for legacy, 1..32 for MSI, or 1..2048 for MSI-X. A legal request produces a single one-cycle pulse on irqReq carrying that kind and vector, and sets status bit 6. An illegal request produces no pulse and leaves bit 6 clear.
- R5: A read fetches the given number of words starting at the source address. The checksum register receives the XOR of all fetched words. Status bit 0 signals success.
- R6: A write stores the words 0, 1, 2, ... at successive words starting at the destination address. The checksum register receives the XOR of those words. Status bit 2 signals success.
- R7: A copy moves the given number of words from the source address to the destination address. The checksum register receives the XOR of the copied words. Status bit 4 signals success.
- R8: An address is invalid when its two low bits are not zero, or when the address plus four times the length exceeds WIN_BYTES. For an invalid address the job makes no memory access. It sets its fail bit (1 read, 3 write, 5 copy), and it also sets bit 7 for a bad source address and bit 8 for a bad destination address. The address range that ends exactly at WIN_BYTES is valid.
- R9: Every read, write or copy, successful or not, ends with a completion request using the kind and vector registers, subject to the legality rule of R4.
- R10: Writing ones to the status word clears those bits. Starting a new command clears all status bits first.
- R11: A command write that arrives while a job is running is ignored. While a memory request waits for acknowledge, its address, direction and data stay stable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 4 | Register word index |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data (combinational on regAddr) |
| memReq | output | 1 | Memory request, held until acknowledged |
| memWe | output | 1 | 1 = write, 0 = read |
| memAddr | output | 32 | Byte address of the word |
| memWdata | output | 32 | Write data |
| memRdata | input | 32 | Read data, valid with memAck |
| memAck | input | 1 | One-cycle completion of the current request |
| irqReq | output | 1 | One-cycle interrupt request |
| irqType | output | 2 | Interrupt kind, valid with irqReq |
| irqNum | output | NUM_W | Interrupt vector, valid with irqReq |

## Verification
The bench sweeps every interrupt kind against the vectors at and just past each legal bound. A range check that is off by one would either emit a pulse at vector 33 or 2049, or drop the pulse at 32 or 2048. The address checks are probed with a misaligned source, a destination one word past the window, and a destination ending exactly on the window edge. A comparison using the wrong relation would either reject the legal edge case or issue memory traffic that the bench's access counter catches. Multi-bit commands, command writes during a running copy and write-one-to-clear status are also exercised, because a wrong priority, a missing busy guard or a status word that is not cleared at start all show up as extra status bits or extra interrupts.

// File: rtl/ep_test_pkg.sv
package ep_test_pkg;

  localparam int REG_IDX_W = 4;
  localparam int STAT_W    = 9;

  // register word indices
  localparam logic [REG_IDX_W-1:0] IX_MAGIC = 4'd0;
  localparam logic [REG_IDX_W-1:0] IX_CMD   = 4'd1;
  localparam logic [REG_IDX_W-1:0] IX_STAT  = 4'd2;
  localparam logic [REG_IDX_W-1:0] IX_SRC   = 4'd3;
  localparam logic [REG_IDX_W-1:0] IX_DST   = 4'd4;
  localparam logic [REG_IDX_W-1:0] IX_LEN   = 4'd5;
  localparam logic [REG_IDX_W-1:0] IX_SUM   = 4'd6;
  localparam logic [REG_IDX_W-1:0] IX_IKIND = 4'd7;
  localparam logic [REG_IDX_W-1:0] IX_IVEC  = 4'd8;

  // status bit positions
  localparam int SB_RD_OK   = 0;
  localparam int SB_RD_FAIL = 1;
  localparam int SB_WR_OK   = 2;
  localparam int SB_WR_FAIL = 3;
  localparam int SB_CP_OK   = 4;
  localparam int SB_CP_FAIL = 5;
  localparam int SB_IRQ     = 6;
  localparam int SB_SRC_BAD = 7;
  localparam int SB_DST_BAD = 8;

  typedef enum logic [2:0] {
    OP_NONE, OP_LEG, OP_MSI, OP_MSIX, OP_RD, OP_WR, OP_CP
  } opKind_e;

  // strobes from control to datapath
  typedef struct packed {
    logic              idle;
    logic              start;
    logic              sumClr;
    logic              rdDone;
    logic              wrDone;
    logic              cntDec;
    logic              fromBuf;
    logic              selDst;
    logic [STAT_W-1:0] setStat;
  } dpCtl_t;

  function automatic logic irqLegal(logic [31:0] kind, logic [31:0] vec);
    case (kind)
      32'd0:   return vec == 32'd0;
      32'd1:   return vec >= 32'd1 && vec <= 32'd32;
      32'd2:   return vec >= 32'd1 && vec <= 32'd2048;
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/ep_test_ctrl.sv
module ep_test_ctrl
  import ep_test_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [5:0]  cmdQ,
  input  logic        srcBad,
  input  logic        dstBad,
  input  logic        cntZero,
  input  logic        cntOne,
  input  logic [31:0] irqKindQ,
  input  logic [31:0] irqVecQ,
  input  logic        memAck,
  output dpCtl_t      ctl,
  output logic        memReq,
  output logic        memWe,
  output logic        irqReq,
  output logic [1:0]  irqType
);

  typedef enum logic [2:0] {S_IDLE, S_CHECK, S_RD, S_WR, S_IRQ} state_e;

  state_e  state, stateNx;
  opKind_e op, opNx;
  logic [31:0] fireKind;
  logic        fireOk;

  function automatic opKind_e pickOp(logic [5:0] c);
    if (c[0]) return OP_LEG;
    if (c[1]) return OP_MSI;
    if (c[2]) return OP_MSIX;
    if (c[3]) return OP_RD;
    if (c[4]) return OP_WR;
    if (c[5]) return OP_CP;
    return OP_NONE;
  endfunction

  always_comb begin
    case (op)
      OP_LEG:  fireKind = 32'd0;
      OP_MSI:  fireKind = 32'd1;
      OP_MSIX: fireKind = 32'd2;
      default: fireKind = irqKindQ;
    endcase
    fireOk  = irqLegal(fireKind, irqVecQ);
    irqType = fireKind[1:0];
  end

  always_comb begin
    ctl     = '0;
    memReq  = 1'b0;
    memWe   = 1'b0;
    irqReq  = 1'b0;
    stateNx = state;
    opNx    = op;
    case (state)
      S_IDLE: begin
        ctl.idle = 1'b1;
        if (cmdQ != 6'd0) begin
          ctl.start = 1'b1;
          opNx      = pickOp(cmdQ);
          stateNx   = S_CHECK;
        end
      end
      S_CHECK: begin
        stateNx = S_IRQ;
        case (op)
          OP_RD: begin
            ctl.sumClr = 1'b1;
            if (srcBad) begin
              ctl.setStat[SB_RD_FAIL] = 1'b1;
              ctl.setStat[SB_SRC_BAD] = 1'b1;
            end else if (cntZero) ctl.setStat[SB_RD_OK] = 1'b1;
            else stateNx = S_RD;
          end
          OP_WR: begin
            ctl.sumClr = 1'b1;
            if (dstBad) begin
              ctl.setStat[SB_WR_FAIL] = 1'b1;
              ctl.setStat[SB_DST_BAD] = 1'b1;
            end else if (cntZero) ctl.setStat[SB_WR_OK] = 1'b1;
            else stateNx = S_WR;
          end
          OP_CP: begin
            ctl.sumClr = 1'b1;
            if (srcBad || dstBad) begin
              ctl.setStat[SB_CP_FAIL] = 1'b1;
              ctl.setStat[SB_SRC_BAD] = srcBad;
              ctl.setStat[SB_DST_BAD] = dstBad;
            end else if (cntZero) ctl.setStat[SB_CP_OK] = 1'b1;
            else stateNx = S_RD;
          end
          default: ;
        endcase
      end
      S_RD: begin
        memReq = 1'b1;
        if (memAck) begin
          ctl.rdDone = 1'b1;
          if (op == OP_CP) stateNx = S_WR;
          else begin
            ctl.cntDec = 1'b1;
            if (cntOne) begin
              ctl.setStat[SB_RD_OK] = 1'b1;
              stateNx = S_IRQ;
            end
          end
        end
      end
      S_WR: begin
        memReq      = 1'b1;
        memWe       = 1'b1;
        ctl.selDst  = 1'b1;
        ctl.fromBuf = (op == OP_CP);
        if (memAck) begin
          ctl.wrDone = 1'b1;
          ctl.cntDec = 1'b1;
          if (cntOne) begin
            ctl.setStat[(op == OP_CP) ? SB_CP_OK : SB_WR_OK] = 1'b1;
            stateNx = S_IRQ;
          end else if (op == OP_CP) stateNx = S_RD;
        end
      end
      S_IRQ: begin
        if (fireOk) begin
          irqReq              = 1'b1;
          ctl.setStat[SB_IRQ] = 1'b1;
        end
        stateNx = S_IDLE;
      end
      default: stateNx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      op    <= OP_NONE;
    end else begin
      state <= stateNx;
      op    <= opNx;
    end
  end

endmodule

// File: rtl/ep_test_dp.sv
module ep_test_dp
  import ep_test_pkg::*;
#(
  parameter int unsigned WIN_BYTES = 4096
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  dpCtl_t               ctl,
  input  logic                 regWe,
  input  logic [REG_IDX_W-1:0] regAddr,
  input  logic [31:0]          regWdata,
  output logic [31:0]          regRdata,
  output logic [31:0]          memAddr,
  output logic [31:0]          memWdata,
  input  logic [31:0]          memRdata,
  output logic [5:0]           cmdQ,
  output logic                 srcBad,
  output logic                 dstBad,
  output logic                 cntZero,
  output logic                 cntOne,
  output logic [31:0]          irqKindQ,
  output logic [31:0]          irqVecQ,
  output logic [STAT_W-1:0]    statusQ
);

  localparam logic [34:0] WIN_END = 35'(WIN_BYTES);

  logic [31:0] magicQ, srcQ, dstQ, lenQ, sumQ;
  logic [31:0] srcPtr, dstPtr, cnt, bufQ, patQ;
  logic [STAT_W-1:0] clrMask;

  function automatic logic spanBad(logic [31:0] a, logic [31:0] n);
    return (a[1:0] != 2'b00) || (({3'b000, a} + {1'b0, n, 2'b00}) > WIN_END);
  endfunction

  assign srcBad   = spanBad(srcPtr, cnt);
  assign dstBad   = spanBad(dstPtr, cnt);
  assign cntZero  = (cnt == 32'd0);
  assign cntOne   = (cnt == 32'd1);
  assign memAddr  = ctl.selDst ? dstPtr : srcPtr;
  assign memWdata = ctl.fromBuf ? bufQ : patQ;
  assign clrMask  = (regWe && regAddr == IX_STAT) ? regWdata[STAT_W-1:0] : '0;

  always_comb begin
    case (regAddr)
      IX_MAGIC: regRdata = magicQ;
      IX_CMD:   regRdata = {26'd0, cmdQ};
      IX_STAT:  regRdata = {{(32-STAT_W){1'b0}}, statusQ};
      IX_SRC:   regRdata = srcQ;
      IX_DST:   regRdata = dstQ;
      IX_LEN:   regRdata = lenQ;
      IX_SUM:   regRdata = sumQ;
      IX_IKIND: regRdata = irqKindQ;
      IX_IVEC:  regRdata = irqVecQ;
      default:  regRdata = 32'd0;
    endcase
  end

  // software-owned registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      magicQ   <= '0;
      srcQ     <= '0;
      dstQ     <= '0;
      lenQ     <= '0;
      irqKindQ <= '0;
      irqVecQ  <= '0;
      cmdQ     <= '0;
      statusQ  <= '0;
    end else begin
      if (regWe) begin
        case (regAddr)
          IX_MAGIC: magicQ   <= regWdata;
          IX_SRC:   srcQ     <= regWdata;
          IX_DST:   dstQ     <= regWdata;
          IX_LEN:   lenQ     <= regWdata;
          IX_IKIND: irqKindQ <= regWdata;
          IX_IVEC:  irqVecQ  <= regWdata;
          default: ;
        endcase
      end
      if (ctl.start) cmdQ <= '0;
      else if (regWe && regAddr == IX_CMD && ctl.idle) cmdQ <= regWdata[5:0];
      if (ctl.start) statusQ <= '0;
      else statusQ <= (statusQ & ~clrMask) | ctl.setStat;
    end
  end

  // job working state
  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcPtr <= '0;
      dstPtr <= '0;
      cnt    <= '0;
      sumQ   <= '0;
      bufQ   <= '0;
      patQ   <= '0;
    end else if (ctl.start) begin
      srcPtr <= srcQ;
      dstPtr <= dstQ;
      cnt    <= lenQ;
    end else begin
      if (ctl.sumClr) begin
        sumQ <= '0;
        patQ <= '0;
      end
      if (ctl.rdDone) begin
        sumQ   <= sumQ ^ memRdata;
        bufQ   <= memRdata;
        srcPtr <= srcPtr + 32'd4;
      end
      if (ctl.wrDone) begin
        dstPtr <= dstPtr + 32'd4;
        if (!ctl.fromBuf) begin
          sumQ <= sumQ ^ patQ;
          patQ <= patQ + 32'd1;
        end
      end
      if (ctl.cntDec) cnt <= cnt - 32'd1;
    end
  end

endmodule

// File: rtl/ep_test_engine.sv
module ep_test_engine
  import ep_test_pkg::*;
#(
  parameter int unsigned WIN_BYTES = 4096,
  parameter int          NUM_W     = 12
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regWe,
  input  logic [REG_IDX_W-1:0] regAddr,
  input  logic [31:0]          regWdata,
  output logic [31:0]          regRdata,
  output logic                 memReq,
  output logic                 memWe,
  output logic [31:0]          memAddr,
  output logic [31:0]          memWdata,
  input  logic [31:0]          memRdata,
  input  logic                 memAck,
  output logic                 irqReq,
  output logic [1:0]           irqType,
  output logic [NUM_W-1:0]     irqNum
);

  dpCtl_t            ctl;
  logic [5:0]        cmdQ;
  logic              srcBad, dstBad, cntZero, cntOne;
  logic [31:0]       irqKindQ, irqVecQ;
  logic [STAT_W-1:0] statusQ;

  assign irqNum = irqVecQ[NUM_W-1:0];

  ep_test_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .cmdQ(cmdQ), .srcBad(srcBad), .dstBad(dstBad),
    .cntZero(cntZero), .cntOne(cntOne), .irqKindQ(irqKindQ), .irqVecQ(irqVecQ),
    .memAck(memAck), .ctl(ctl), .memReq(memReq), .memWe(memWe),
    .irqReq(irqReq), .irqType(irqType)
  );

  ep_test_dp #(.WIN_BYTES(WIN_BYTES)) uDp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .memAddr(memAddr),
    .memWdata(memWdata), .memRdata(memRdata), .cmdQ(cmdQ), .srcBad(srcBad),
    .dstBad(dstBad), .cntZero(cntZero), .cntOne(cntOne),
    .irqKindQ(irqKindQ), .irqVecQ(irqVecQ), .statusQ(statusQ)
  );

endmodule

// File: rtl/ep_test_engine_chk.sv
module ep_test_engine_chk #(
  parameter int unsigned WIN_BYTES = 4096,
  parameter int          NUM_W     = 12
) (
  input logic             clk,
  input logic             rstN,
  input logic             memReq,
  input logic             memWe,
  input logic [31:0]      memAddr,
  input logic [31:0]      memWdata,
  input logic             memAck,
  input logic             irqReq,
  input logic [1:0]       irqType,
  input logic [NUM_W-1:0] irqNum,
  input logic [8:0]       statusQ
);

  // R4: the request lasts exactly one cycle
  a_r4_irq_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |=> !irqReq);

  // R4: kind and vector form a legal pair whenever a request is raised
  a_r4_irq_legal: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> ((irqType == 2'd0 && irqNum == 0) ||
                (irqType == 2'd1 && irqNum >= 1 && irqNum <= 32) ||
                (irqType == 2'd2 && irqNum >= 1 && irqNum <= 2048)));

  // R4, R9: a raised request is recorded in status bit 6
  a_r9_irq_recorded: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |=> statusQ[6]);

  // R8: traffic is word aligned
  a_r8_mem_aligned: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> memAddr[1:0] == 2'b00);

  // R8: traffic stays inside the host window
  a_r8_mem_in_window: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> {1'b0, memAddr} < 33'(WIN_BYTES));

  // R11: a pending request is held steady
  a_r11_req_held: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memAck |=> memReq && $stable(memAddr) && $stable(memWe) &&
                          (!memWe || $stable(memWdata)));

endmodule

bind ep_test_engine ep_test_engine_chk #(.WIN_BYTES(WIN_BYTES), .NUM_W(NUM_W)) uChk (
  .clk(clk), .rstN(rstN), .memReq(memReq), .memWe(memWe), .memAddr(memAddr),
  .memWdata(memWdata), .memAck(memAck), .irqReq(irqReq), .irqType(irqType),
  .irqNum(irqNum), .statusQ(statusQ)
);

// File: tb/ep_test_engine_test.sv
module ep_test_engine_test;

  localparam int WORDS = 1024;
  localparam int WIN   = WORDS * 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic [3:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        memReq, memWe;
  logic [31:0] memAddr, memWdata;
  logic [31:0] memRdata = '0;
  logic        memAck = 1'b0;
  logic        irqReq;
  logic [1:0]  irqType;
  logic [11:0] irqNum;

  logic [31:0] mem [WORDS];
  int          accCnt = 0;
  int          irqCnt = 0;
  logic [1:0]  lastType = '0;
  logic [11:0] lastNum = '0;
  int          nChecks = 0;
  int          nFails = 0;

  always #5 clk = ~clk;

  ep_test_engine #(.WIN_BYTES(WIN), .NUM_W(12)) uut (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .memReq(memReq), .memWe(memWe),
    .memAddr(memAddr), .memWdata(memWdata), .memRdata(memRdata),
    .memAck(memAck), .irqReq(irqReq), .irqType(irqType), .irqNum(irqNum)
  );

  // host memory: acknowledges a held request one cycle later
  always @(posedge clk) begin
    memAck <= 1'b0;
    if (rstN && memReq && !memAck) begin
      memAck <= 1'b1;
      accCnt <= accCnt + 1;
      if (memWe) mem[memAddr[11:2]] <= memWdata;
      else memRdata <= mem[memAddr[11:2]];
    end
  end

  always @(posedge clk) begin
    if (rstN && irqReq) begin
      irqCnt   <= irqCnt + 1;
      lastType <= irqType;
      lastNum  <= irqNum;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdata;
  endtask

  task automatic expectReg(input logic [3:0] a, input logic [31:0] exp, input string req);
    logic [31:0] v;
    rd(a, v);
    check(v === exp, req, v, exp);
  endtask

  task automatic runCmd(input logic [31:0] c, input int cyc);
    wr(4'd1, c);
    repeat (cyc) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFails++;
    nChecks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    logic [31:0] v, sum;
    int ic, ac;
    for (int i = 0; i < WORDS; i++) mem[i] = 32'h1000_0000 + i * 32'h0101_0037;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1/R2 reset state
    for (int a = 0; a < 9; a++) expectReg(4'(a), 32'd0, "R1 reset zero");
    check(irqReq === 1'b0 && memReq === 1'b0, "R2 reset outputs", {30'd0, irqReq, memReq}, 0);

    // R1 scratch pattern
    foreach (v[i]) begin
      wr(4'd0, 32'h1 << i ^ 32'h5A5A_0000);
      expectReg(4'd0, 32'h1 << i ^ 32'h5A5A_0000, "R1 scratch readback");
    end
    wr(4'd6, 32'hDEAD_BEEF);
    expectReg(4'd6, 32'd0, "R2 checksum write ignored");
    expectReg(4'd12, 32'd0, "R2 unmapped reads zero");

    // R4 interrupt sweep over kinds and boundary vectors
    for (int b = 0; b < 3; b++) begin
      for (int k = 0; k < 7; k++) begin
        int n;
        bit ok;
        case (k)
          0: n = 0; 1: n = 1; 2: n = 2; 3: n = 32; 4: n = 33; 5: n = 2048;
          default: n = 2049;
        endcase
        ok = (b == 0) ? (n == 0) : (b == 1) ? (n >= 1 && n <= 32) : (n >= 1 && n <= 2048);
        wr(4'd8, n);
        ic = irqCnt;
        runCmd(32'h1 << b, 8);
        check(irqCnt - ic == (ok ? 1 : 0), "R4 pulse count", irqCnt - ic, ok ? 1 : 0);
        expectReg(4'd2, ok ? 32'h40 : 32'h0, "R4 status bit 6");
        if (ok) check(lastType == 2'(b) && lastNum == 12'(n), "R4 kind and vector",
                      {18'd0, lastType, lastNum}, {18'd0, 2'(b), 12'(n)});
      end
    end
    expectReg(4'd1, 32'd0, "R3 command reads zero after start");

    // R3 priority: legacy bit wins over read
    wr(4'd8, 0);
    ic = irqCnt; ac = accCnt;
    runCmd(32'h38 | 32'h1, 40);
    check(irqCnt - ic == 1 && lastType == 2'd0 && accCnt == ac, "R3 lowest bit wins",
          {irqCnt - ic, 30'(lastType)}, 1);
    expectReg(4'd2, 32'h40, "R3 no buffer status");

    // completion interrupt setup: MSI vector 5
    wr(4'd7, 1); wr(4'd8, 5);

    // R5 read
    wr(4'd3, 32'h100); wr(4'd5, 7);
    sum = 0;
    for (int i = 0; i < 7; i++) sum ^= mem[64 + i];
    ic = irqCnt; ac = accCnt;
    runCmd(32'h08, 60);
    expectReg(4'd6, sum, "R5 read checksum");
    expectReg(4'd2, 32'h41, "R5 read success status");
    check(accCnt - ac == 7, "R5 read word count", accCnt - ac, 7);
    check(irqCnt - ic == 1 && lastType == 2'd1 && lastNum == 12'd5, "R9 completion irq",
          {18'd0, lastType, lastNum}, {18'd0, 2'd1, 12'd5});

    // R10 write-one-to-clear
    wr(4'd2, 32'h01);
    expectReg(4'd2, 32'h40, "R10 w1c clears bit 0 only");

    // R6 write
    wr(4'd4, 32'h200); wr(4'd5, 5);
    runCmd(32'h10, 40);
    for (int i = 0; i < 5; i++) check(mem[128 + i] == i, "R6 pattern word", mem[128 + i], i);
    expectReg(4'd6, 32'h4, "R6 write checksum");
    expectReg(4'd2, 32'h44, "R6 write success status");

    // R7 copy
    wr(4'd3, 32'h100); wr(4'd4, 32'h300); wr(4'd5, 6);
    sum = 0;
    for (int i = 0; i < 6; i++) sum ^= mem[64 + i];
    runCmd(32'h20, 80);
    for (int i = 0; i < 6; i++) check(mem[192 + i] == mem[64 + i], "R7 copied word",
                                       mem[192 + i], mem[64 + i]);
    expectReg(4'd6, sum, "R7 copy checksum");
    expectReg(4'd2, 32'h50, "R7 copy success status");

    // R8 misaligned source on read
    wr(4'd3, 32'h102); wr(4'd5, 2);
    ic = irqCnt; ac = accCnt;
    runCmd(32'h08, 20);
    expectReg(4'd2, 32'hC2, "R8 misaligned source status");
    check(accCnt == ac, "R8 no access on bad source", accCnt - ac, 0);
    check(irqCnt - ic == 1, "R9 irq after failure", irqCnt - ic, 1);

    // R8 destination one word past window
    wr(4'd4, WIN - 12); wr(4'd5, 4);
    ac = accCnt;
    runCmd(32'h10, 20);
    expectReg(4'd2, 32'h148, "R8 destination past window");
    check(accCnt == ac, "R8 no access on bad destination", accCnt - ac, 0);

    // R8 destination ending exactly on window edge
    wr(4'd4, WIN - 16);
    runCmd(32'h10, 40);
    expectReg(4'd2, 32'h44, "R8 edge range accepted");
    check(mem[WORDS - 1] == 3, "R8 last word written", mem[WORDS - 1], 3);

    // R8 copy with both addresses bad
    wr(4'd3, 32'h1); wr(4'd4, WIN);
    runCmd(32'h20, 20);
    expectReg(4'd2, 32'h1E0, "R8 copy both bad");

    // R9 illegal completion pair: no pulse, bit 6 clear
    wr(4'd7, 0); wr(4'd8, 3); wr(4'd3, 32'h100); wr(4'd5, 0);
    ic = irqCnt;
    runCmd(32'h08, 20);
    expectReg(4'd2, 32'h01, "R9 no irq for illegal pair");
    expectReg(4'd6, 32'h0, "R5 empty read checksum");
    check(irqCnt == ic, "R9 pulse suppressed", irqCnt - ic, 0);

    // R11 command write while busy is ignored
    wr(4'd7, 2); wr(4'd8, 2048);
    wr(4'd3, 32'h100); wr(4'd4, 32'h800); wr(4'd5, 16);
    ic = irqCnt; ac = accCnt;
    wr(4'd1, 32'h20);
    repeat (6) @(negedge clk);
    wr(4'd1, 32'h08);
    expectReg(4'd1, 32'd0, "R11 busy command not stored");
    repeat (200) @(negedge clk);
    expectReg(4'd2, 32'h50, "R11 only copy status");
    check(irqCnt - ic == 1 && accCnt - ac == 32, "R11 single job",
          accCnt - ac, 32);

    // R10 new command clears old status
    wr(4'd8, 0);
    runCmd(32'h02, 8);
    expectReg(4'd2, 32'h0, "R10 status cleared by new command");

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule